// File: doc/BRIEF.md
# Dual-Width ALU with Split Carries

This block is the arithmetic and flag unit of a 16-bit processor that runs 8-bit legacy code unchanged. Each instruction picks its own width: if the upper byte of the instruction word is zero, the operation runs in 8-bit mode. If that byte is nonzero, the operation runs in 16-bit mode. The block computes a 16-bit result combinationally from two operands and a decoded operation code. When `exec` is high, it registers the new flags.

The unit keeps two carry flags. One is the carry out of the low byte and the other is the carry out of the full word. Every add, subtract, increment, decrement and shift updates both. The width of the current instruction decides three things: which carry is consumed, which bits form the zero and negative flags, and which sign bit the overflow flag follows. Carry-based branches test the carry that matches their own width and also produce a branch target from a signed 16-bit offset.

Top module: `split_carry_alu`

## Requirements
- R1: The mode is 16-bit when `instr[15:8]` is nonzero and 8-bit when it is zero, and it is decided anew for every operation. Op codes: 0 add-with-carry, 1 subtract-with-borrow, 2 increment, 3 decrement, 4 AND, 5 OR, 6 XOR, 7 load (pass `opnd_b`), 8 shift left, 9 shift right, 10 rotate left, 11 rotate right, 12 branch if carry clear, 13 branch if carry set, 14 and 15 no operation.
- R2: Add computes `opnd_a + opnd_b + cin` over the full word. `cin` is the 16-bit carry in 16-bit mode and the 8-bit carry in 8-bit mode. The new 16-bit carry is the carry out of bit 15, and the new 8-bit carry is the carry out of bit 7.
- R3: Subtract computes `opnd_a + ~opnd_b + cin`, with `cin` chosen as in R2 and both carries formed as in R2. A set carry means no borrow.
- R4: In 8-bit mode the zero flag is set when `result[7:0]` is 0 and the negative flag is `result[7]`. In 16-bit mode the zero flag is set when `result` is 0 and the negative flag is `result[15]`. This applies to ops 0 to 11.
- R5: For add and subtract, overflow is set when both addends share a sign that differs from the result's sign. The sign bit is bit 7 in 8-bit mode and bit 15 in 16-bit mode.
- R6: Increment and decrement act on the whole 16-bit word in both modes and leave overflow unchanged. Increment sets the 16-bit carry on a wrap from FFFF and the 8-bit carry on a low-byte wrap from FF. Decrement sets each carry when the word or the low byte, respectively, was nonzero.
- R7: AND, OR, XOR and load leave both carries and overflow unchanged.
- R8: Shift left and rotate left move bit 0 in from 0 (shift) or from the mode's carry (rotate). In 8-bit mode only the low byte moves and the high byte is kept. The 8-bit carry takes old bit 7 and the 16-bit carry takes old bit 15.
- R9: Shift right and rotate right move 0 (shift) or the mode's carry (rotate) into bit 7 in 8-bit mode and into bit 15 in 16-bit mode. In 8-bit mode the high byte is kept. Both carries take old bit 0.
- R10: Branch ops set `result` to `opnd_a + opnd_b`, where `opnd_b` is a signed 16-bit offset. `br_taken` tests the mode's carry: carry clear for op 12 and carry set for op 13. All flags stay unchanged.
- R11: Flags change only on a clock edge with `exec` high. Reset clears every flag to 0.
- R12: Ops 14 and 15 give a zero result, `br_taken` low, and unchanged flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Commit the flags of this operation |
| instr | input | 16 | Instruction word; its upper byte picks the width |
| op | input | 4 | Decoded operation code |
| opnd_a | input | 16 | First operand, or the PC for branches |
| opnd_b | input | 16 | Second operand, or the branch offset |
| result | output | 16 | Combinational result |
| br_taken | output | 1 | Carry-based branch condition |
| flag_c8 | output | 1 | Carry out of the low byte |
| flag_c16 | output | 1 | Carry out of the full word |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Random operands are run with random op codes, with half of the instruction words having a zero upper byte. This shows whether each op takes its carry-in, its zero test and its sign bit from the correct width. Directed cases load operands that produce different carries from the low byte and the full word, such as 00FF+0001 and FF00+0100. Consuming those carries in the other mode through rotates and branches then tells apart a design that mixes up the two carries. Further directed cases cover wraps at FFFF and 0000, and 8-bit shifts whose high byte must stay fixed. Ops with `exec` low check that the flags hold.

// File: rtl/sca_pkg.sv
package sca_pkg;

    typedef enum logic [3:0] {
        OP_ADC = 4'd0,
        OP_SBC = 4'd1,
        OP_INC = 4'd2,
        OP_DEC = 4'd3,
        OP_AND = 4'd4,
        OP_ORA = 4'd5,
        OP_EOR = 4'd6,
        OP_LDA = 4'd7,
        OP_ASL = 4'd8,
        OP_LSR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_BCC = 4'd12,
        OP_BCS = 4'd13,
        OP_NP0 = 4'd14,
        OP_NP1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic c8;
        logic c16;
        logic z;
        logic n;
        logic v;
    } alu_flags_t;

    function automatic logic is_logic_op(alu_op_e o);
        return (o == OP_AND) || (o == OP_ORA) || (o == OP_EOR) || (o == OP_LDA);
    endfunction

    function automatic logic is_branch_op(alu_op_e o);
        return (o == OP_BCC) || (o == OP_BCS);
    endfunction

endpackage

// File: rtl/sca_arith.sv
module sca_arith
    import sca_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic           mode_wide,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c8_in,
    input  logic           c16_in,
    output logic [W-1:0]   sum,
    output logic           cout_lo,
    output logic           cout_hi,
    output logic           ovf_lo,
    output logic           ovf_hi
);
    localparam int H = W / 2;

    logic [W-1:0] addend;
    logic         ci;
    logic         cin_sel;
    logic [H:0]   lo_sum;
    logic [W:0]   full_sum;

    always_comb begin
        cin_sel = mode_wide ? c16_in : c8_in;
        case (op)
            OP_ADC:         begin addend = b;        ci = cin_sel; end
            OP_SBC:         begin addend = ~b;       ci = cin_sel; end
            OP_INC:         begin addend = '0;       ci = 1'b1;    end
            OP_DEC:         begin addend = '1;       ci = 1'b0;    end
            OP_BCC, OP_BCS: begin addend = b;        ci = 1'b0;    end
            default:        begin addend = '0;       ci = 1'b0;    end
        endcase
        lo_sum   = {1'b0, a[H-1:0]} + {1'b0, addend[H-1:0]} + {{H{1'b0}}, ci};
        full_sum = {1'b0, a} + {1'b0, addend} + {{W{1'b0}}, ci};
        sum      = full_sum[W-1:0];
        cout_lo  = lo_sum[H];
        cout_hi  = full_sum[W];
        ovf_lo   = (a[H-1] == addend[H-1]) && (full_sum[H-1] != a[H-1]);
        ovf_hi   = (a[W-1] == addend[W-1]) && (full_sum[W-1] != a[W-1]);
    end

    // R6: a full-word increment of all ones must wrap to zero with carry out
    always_comb begin
        if (op == OP_INC && a == '1) begin
            a_inc_wrap_r6: assert (sum == '0 && cout_hi && cout_lo);
        end
    end

endmodule

// File: rtl/sca_shift.sv
module sca_shift
    import sca_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic           mode_wide,
    input  logic [W-1:0]   a,
    input  logic           c8_in,
    input  logic           c16_in,
    output logic [W-1:0]   res,
    output logic           out_lo,
    output logic           out_hi
);
    localparam int H = W / 2;

    logic fill;

    always_comb begin
        case (op)
            OP_ROL, OP_ROR: fill = mode_wide ? c16_in : c8_in;
            default:        fill = 1'b0;
        endcase
        case (op)
            OP_ASL, OP_ROL: begin
                if (mode_wide) res = {a[W-2:0], fill};
                else           res = {a[W-1:H], a[H-2:0], fill};
                out_lo = a[H-1];
                out_hi = a[W-1];
            end
            OP_LSR, OP_ROR: begin
                if (mode_wide) res = {fill, a[W-1:1]};
                else           res = {a[W-1:H], fill, a[H-1:1]};
                out_lo = a[0];
                out_hi = a[0];
            end
            default: begin
                res    = '0;
                out_lo = 1'b0;
                out_hi = 1'b0;
            end
        endcase
    end

    // R8, R9: a narrow shift never disturbs the upper byte
    always_comb begin
        if (!mode_wide && (op == OP_ASL || op == OP_LSR || op == OP_ROL || op == OP_ROR)) begin
            a_hi_kept_r9: assert (res[W-1:H] == a[W-1:H]);
        end
    end

endmodule

// File: rtl/sca_logic.sv
module sca_logic
    import sca_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            case (op)
                OP_AND:  res[i] = a[i] & b[i];
                OP_ORA:  res[i] = a[i] | b[i];
                OP_EOR:  res[i] = a[i] ^ b[i];
                OP_LDA:  res[i] = b[i];
                default: res[i] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/split_carry_alu.sv
module split_carry_alu
    import sca_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  logic [DATA_W-1:0] instr,
    input  logic [3:0]        op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              br_taken,
    output logic              flag_c8,
    output logic              flag_c16,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_v
);
    localparam int H = DATA_W / 2;

    alu_op_e      op_e;
    logic         mode_wide;
    alu_flags_t   flags_d, flags_q;
    logic [DATA_W-1:0] arith_sum, shift_res, logic_res;
    logic         a_clo, a_chi, a_vlo, a_vhi, s_clo, s_chi;
    logic         unused_instr_lo;

    assign op_e            = alu_op_e'(op);
    assign mode_wide       = |instr[DATA_W-1:H];
    assign unused_instr_lo = ^instr[H-1:0];

    sca_arith #(.W(DATA_W)) u_arith (
        .op(op_e), .mode_wide(mode_wide), .a(opnd_a), .b(opnd_b),
        .c8_in(flags_q.c8), .c16_in(flags_q.c16), .sum(arith_sum),
        .cout_lo(a_clo), .cout_hi(a_chi), .ovf_lo(a_vlo), .ovf_hi(a_vhi)
    );

    sca_shift #(.W(DATA_W)) u_shift (
        .op(op_e), .mode_wide(mode_wide), .a(opnd_a),
        .c8_in(flags_q.c8), .c16_in(flags_q.c16), .res(shift_res),
        .out_lo(s_clo), .out_hi(s_chi)
    );

    sca_logic #(.W(DATA_W)) u_logic (
        .op(op_e), .a(opnd_a), .b(opnd_b), .res(logic_res)
    );

    always_comb begin
        alu_flags_t nxt;
        logic       csel;
        logic       zn_upd;
        nxt      = flags_q;
        csel     = mode_wide ? flags_q.c16 : flags_q.c8;
        zn_upd   = 1'b1;
        br_taken = 1'b0;
        case (op_e)
            OP_ADC, OP_SBC: begin
                result  = arith_sum;
                nxt.c8  = a_clo;
                nxt.c16 = a_chi;
                nxt.v   = mode_wide ? a_vhi : a_vlo;
            end
            OP_INC, OP_DEC: begin
                result  = arith_sum;
                nxt.c8  = a_clo;
                nxt.c16 = a_chi;
            end
            OP_AND, OP_ORA, OP_EOR, OP_LDA: begin
                result = logic_res;
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                result  = shift_res;
                nxt.c8  = s_clo;
                nxt.c16 = s_chi;
            end
            OP_BCC, OP_BCS: begin
                result   = arith_sum;
                zn_upd   = 1'b0;
                br_taken = (op_e == OP_BCS) ? csel : !csel;
            end
            default: begin
                result = '0;
                zn_upd = 1'b0;
            end
        endcase
        if (zn_upd) begin
            nxt.z = mode_wide ? (result == '0) : (result[H-1:0] == '0);
            nxt.n = mode_wide ? result[DATA_W-1] : result[H-1];
        end
        flags_d = exec ? nxt : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flag_c8  = flags_q.c8;
    assign flag_c16 = flags_q.c16;
    assign flag_z   = flags_q.z;
    assign flag_n   = flags_q.n;
    assign flag_v   = flags_q.v;

    // R11: idle cycles keep every flag
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(flags_q));

    // R7: logic and load leave carries and overflow alone
    p_logic_keeps_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_logic_op(op_e)) |=> $stable({flag_c8, flag_c16, flag_v}));

    // R10: branches change no flag
    p_branch_keeps_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && is_branch_op(op_e)) |=> $stable(flags_q));

    // R4: narrow logic ops set zero from the low byte only
    p_narrow_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !mode_wide && is_logic_op(op_e)) |=> (flag_z == ($past(result[H-1:0]) == '0)));

    // R12: no-operation codes give no result and no branch
    p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_NP0 || op_e == OP_NP1) |-> (result == '0 && !br_taken));

endmodule

// File: tb/split_carry_alu_bench.sv
module split_carry_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  op = '0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [15:0] result;
    logic        br_taken, flag_c8, flag_c16, flag_z, flag_n, flag_v;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // model flags: {c8, c16, z, n, v}
    logic [4:0] mflags = '0;

    always #10 clk = ~clk;

    split_carry_alu u_split_carry_alu (
        .clk(clk), .rst_n(rst_n), .exec(exec), .instr(instr), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .br_taken(br_taken),
        .flag_c8(flag_c8), .flag_c16(flag_c16), .flag_z(flag_z),
        .flag_n(flag_n), .flag_v(flag_v)
    );

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'd0:  return "R2";
            4'd1:  return "R3";
            4'd2, 4'd3: return "R6";
            4'd4, 4'd5, 4'd6, 4'd7: return "R7";
            4'd8, 4'd10: return "R8";
            4'd9, 4'd11: return "R9";
            4'd12, 4'd13: return "R10";
            default: return "R12";
        endcase
    endfunction

    // returns {taken, c8, c16, z, n, v, result}
    function automatic logic [21:0] model(logic [15:0] ins, logic [3:0] o,
                                          logic [15:0] a, logic [15:0] b, logic [4:0] f);
        logic        w, c8, c16, z, n, v, cs, tk, zn;
        logic [31:0] s, lo;
        logic [15:0] r, bb;
        w = (ins[15:8] != 8'h00);
        {c8, c16, z, n, v} = f;
        cs = w ? c16 : c8;
        tk = 1'b0; zn = 1'b1; r = 16'h0;
        case (o)
            4'd0, 4'd1: begin
                bb  = (o == 4'd1) ? ~b : b;
                s   = 32'(a) + 32'(bb) + 32'(cs);
                lo  = 32'(a[7:0]) + 32'(bb[7:0]) + 32'(cs);
                r   = s[15:0];
                c16 = s[16];
                c8  = lo[8];
                v   = w ? (((a ^ r) & (bb ^ r) & 16'h8000) != 0)
                        : (((a ^ r) & (bb ^ r) & 16'h0080) != 0);
            end
            4'd2: begin r = a + 16'd1; c16 = (a == 16'hFFFF); c8 = (a[7:0] == 8'hFF); end
            4'd3: begin r = a - 16'd1; c16 = (a != 0); c8 = (a[7:0] != 0); end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = b;
            4'd8, 4'd10: begin
                logic fin;
                fin = (o == 4'd10) ? cs : 1'b0;
                if (w) r = (a << 1) | 16'(fin);
                else   r = (a & 16'hFF00) | ((a << 1) & 16'h00FE) | 16'(fin);
                c8 = a[7]; c16 = a[15];
            end
            4'd9, 4'd11: begin
                logic fin;
                fin = (o == 4'd11) ? cs : 1'b0;
                if (w) r = (a >> 1) | (16'(fin) << 15);
                else   r = (a & 16'hFF00) | ((a & 16'h00FF) >> 1) | (16'(fin) << 7);
                c8 = a[0]; c16 = a[0];
            end
            4'd12, 4'd13: begin
                r  = a + b;
                tk = (o == 4'd13) ? cs : !cs;
                zn = 1'b0;
            end
            default: zn = 1'b0;
        endcase
        if (zn) begin
            z = w ? (r == 0) : (r[7:0] == 0);
            n = w ? r[15] : r[7];
        end
        return {tk, c8, c16, z, n, v, r};
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(logic [15:0] ins, logic [3:0] o, logic [15:0] a,
                          logic [15:0] b, logic ex);
        logic [21:0] e;
        string rq;
        @(negedge clk);
        instr = ins; op = o; opnd_a = a; opnd_b = b; exec = ex;
        e  = model(ins, o, a, b, mflags);
        rq = ex ? req_of(o) : "R11";
        #2;
        check(req_of(o), "result", 32'(result), 32'(e[15:0]));
        check("R10", "br_taken", 32'(br_taken), 32'(e[21]));
        @(posedge clk);
        #2;
        if (ex) mflags = e[20:16];
        check(rq, "flags", 32'({flag_c8, flag_c16, flag_z, flag_n, flag_v}), 32'(mflags));
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #2;
        // R11: reset clears all flags
        check("R11", "reset flags", 32'({flag_c8, flag_c16, flag_z, flag_n, flag_v}), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R1: 00FF+0001 carries out of the low byte only
        run_op(16'h0069, 4'd0, 16'h00FF, 16'h0001, 1'b1);
        // R1: wide rotate right consumes the 16-bit carry (clear) -> bit 15 stays 0
        run_op(16'h0169, 4'd11, 16'h0002, 16'h0000, 1'b1);
        // R2: FF00+0100 carries out of the full word only
        run_op(16'h0169, 4'd0, 16'hFF00, 16'h0100, 1'b1);
        // R9: narrow rotate uses the 8-bit carry (clear) while the 16-bit carry is set
        run_op(16'h0169, 4'd0, 16'hFF00, 16'h0100, 1'b1);
        run_op(16'h006A, 4'd11, 16'hAB03, 16'h0000, 1'b1);
        // R10: branch width selects the carry; negative offset
        run_op(16'h0090, 4'd13, 16'h1000, 16'hFFFE, 1'b1);
        run_op(16'h0190, 4'd13, 16'h1000, 16'h8000, 1'b1);
        // R6: wraps at both ends, narrow and wide
        run_op(16'h00E6, 4'd2, 16'hFFFF, 16'h0000, 1'b1);
        run_op(16'h01E6, 4'd2, 16'h00FF, 16'h0000, 1'b1);
        run_op(16'h00C6, 4'd3, 16'h0100, 16'h0000, 1'b1);
        run_op(16'h01C6, 4'd3, 16'h0000, 16'h0000, 1'b1);
        // R3 / R5: signed overflow at bit 7 and bit 15
        run_op(16'h00E9, 4'd1, 16'h0080, 16'h0001, 1'b1);
        run_op(16'h01E9, 4'd1, 16'h8000, 16'h0001, 1'b1);
        run_op(16'h0069, 4'd0, 16'h007F, 16'h0001, 1'b1);
        // R4: narrow zero with nonzero high byte
        run_op(16'h00A9, 4'd7, 16'h0000, 16'h5500, 1'b1);
        run_op(16'h01A9, 4'd7, 16'h0000, 16'h5500, 1'b1);
        // R8: narrow left shift keeps high byte, carries from bits 7 and 15
        run_op(16'h000A, 4'd8, 16'h8081, 16'h0000, 1'b1);
        run_op(16'h002A, 4'd10, 16'h0180, 16'h0000, 1'b1);
        // R11: exec low leaves flags as they were
        run_op(16'h0169, 4'd0, 16'hFFFF, 16'hFFFF, 1'b0);
        // R12: no-operation codes
        run_op(16'h0100, 4'd14, 16'h1234, 16'h5678, 1'b1);
        run_op(16'h0000, 4'd15, 16'h1234, 16'h5678, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] ins;
            ins = 16'($urandom);
            if ($urandom % 2 == 0) ins[15:8] = 8'h00;
            run_op(ins, 4'($urandom), 16'($urandom), 16'($urandom), ($urandom % 8) != 0);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule